// File: doc/BRIEF.md
# Timer Master Trigger Output Generator

This block is one slice of a 16-bit up-counting timer whose job is to hand a synchronisation signal (TRGO) to other timers. It holds a counter with a reload limit, a software update strobe, four compare channels that each give a reference level, and a slave trigger path. The trigger path can gate the counter enable or re-initialise the counter. A 3-bit master mode field picks which of eight internal events or levels drives TRGO. A DMA-select bit decides whether each channel's DMA request follows its own compare match or the update event.

The trigger can come from the slave trigger pin or from the external trigger pin. The external pin passes through a polarity stage first. All settings are written through a plain write port (strobe, address, data). There is no read path.

Top module: `tmr_trig_master`

## Requirements
- R1: After a synchronous active-low reset, every register is zero: master mode is 000, the counter is 0, the channel-1 flag is clear, and TRGO and all DMA requests are low.
- R2: Master mode 000 drives TRGO high in the cycle in which a write to address 3 has bit 0 set (the update strobe). In reset slave mode, a trigger rising edge clears the counter at the next edge, and TRGO pulses one cycle after that rising edge.
- R3: Master mode 001 drives TRGO with the counter enable. The enable is the OR of the software enable (address 0, bit 0) and, in gated slave mode, the trigger registered once. A trigger change reaches TRGO one cycle later; a software enable write reaches it in the cycle right after the write edge.
- R4: Master mode 010 drives TRGO with the one-cycle update event. The update event comes from the strobe, a reset-mode trigger, or an enabled counter wrap.
- R5: Master mode 011 pulses TRGO for one cycle on every channel-1 match (enabled counter equal to compare 1), including matches that occur while the channel-1 flag is already set.
- R6: Master modes 100, 101, 110 and 111 drive TRGO with the compare reference of channel 1, 2, 3 and 4; a reference is high while the counter is below that channel's compare value.
- R7: With the DMA-select bit (address 1, bit 3) at 0, request bit i pulses on channel i's match; with it at 1, all request bits pulse on the update event.
- R8: Slave config (address 2) holds the slave mode in bits 1:0 (01 gated, 10 reset, others off), the trigger source in bit 2 (1 = external pin), and the external polarity in bit 3 (1 inverts the pin, making low the active level).
- R9: An enabled counter increments each cycle; at the reload value (address 4) it returns to 0. The update strobe or a reset-mode trigger edge clears it regardless of enable.
- R10: The channel-1 flag sets on a channel-1 match and clears on a write to address 3 with bit 1 set; a match in the same cycle wins. Compare values for channels 1..4 sit at addresses 8..11; master mode sits in address 1, bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address |
| cfg_wdata | input | 16 | Register write data |
| slv_trig_in | input | 1 | Slave trigger input |
| ext_trig_in | input | 1 | External trigger pin, before polarity |
| trgo | output | 1 | Selected master trigger output |
| dma_req | output | 4 | Per-channel DMA request pulses |
| cc1_flag | output | 1 | Channel-1 match flag |

## Verification
The collision of interest is a channel-1 match falling in the same cycle as a counter wrap, so that the match pulse, the update event and both DMA request sources fire together. It is provoked by setting compare 1 equal to the reload value in half of the configurations. A cycle-by-cycle reference model predicts TRGO, every request bit and the flag. That model is run across all eight master modes with both DMA selections, covering gated, inverted external and reset-mode trigger phases. A second coincidence, a flag clear landing on a match, is judged by the set-wins rule.

// File: rtl/tmr_trig_pkg.sv
// Shared encodings for the master trigger timer slice.
// Assumes the master mode field is always 3 bits wide.
package tmr_trig_pkg;

    typedef enum logic [2:0] {
        MM_UG   = 3'd0,
        MM_EN   = 3'd1,
        MM_UPD  = 3'd2,
        MM_CMPP = 3'd3,
        MM_REF1 = 3'd4,
        MM_REF2 = 3'd5,
        MM_REF3 = 3'd6,
        MM_REF4 = 3'd7
    } mm_e;

    typedef enum logic [1:0] {
        SLV_OFF   = 2'd0,
        SLV_GATE  = 2'd1,
        SLV_RESET = 2'd2,
        SLV_RSVD  = 2'd3
    } slv_e;

    localparam int unsigned ADR_CTRL = 0;
    localparam int unsigned ADR_MCFG = 1;
    localparam int unsigned ADR_SCFG = 2;
    localparam int unsigned ADR_EVG  = 3;
    localparam int unsigned ADR_ARR  = 4;
    localparam int unsigned ADR_CCR0 = 8;

    typedef struct packed {
        logic sw_en;
        mm_e  mode;
        logic dma_upd;
        slv_e slv_mode;
        logic trig_ext;
        logic ext_inv;
    } cfg_t;

endpackage

// File: rtl/tmr_cfg_regs.sv
// Configuration register file. It decodes the write port into control
// fields, the reload and compare values, and two write-only strobes.
// Assumes ADR_CCR0 + N_CH fits in ADDR_W bits; there is no read path.
module tmr_cfg_regs
    import tmr_trig_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned N_CH   = 4,
    parameter int unsigned ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [ADDR_W-1:0]       cfg_addr,
    input  logic [CNT_W-1:0]        cfg_wdata,
    output cfg_t                    cfg,
    output logic [CNT_W-1:0]        arr,
    output logic [N_CH*CNT_W-1:0]   ccr,
    output logic                    ug,
    output logic                    flag_clr
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
    localparam logic [ADDR_W-1:0] A_MCFG = ADDR_W'(ADR_MCFG);
    localparam logic [ADDR_W-1:0] A_SCFG = ADDR_W'(ADR_SCFG);
    localparam logic [ADDR_W-1:0] A_EVG  = ADDR_W'(ADR_EVG);
    localparam logic [ADDR_W-1:0] A_ARR  = ADDR_W'(ADR_ARR);

    logic evg_wr;

    // Event register strobes are valid only in the write cycle.
    always_comb begin
        evg_wr   = cfg_we && (cfg_addr == A_EVG);
        ug       = evg_wr && cfg_wdata[0];
        flag_clr = evg_wr && cfg_wdata[1];
    end

    // Control fields and reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
            arr <= '0;
        end else if (cfg_we) begin
            if (cfg_addr == A_CTRL) begin
                cfg.sw_en <= cfg_wdata[0];
            end
            if (cfg_addr == A_MCFG) begin
                cfg.mode    <= mm_e'(cfg_wdata[2:0]);
                cfg.dma_upd <= cfg_wdata[3];
            end
            if (cfg_addr == A_SCFG) begin
                cfg.slv_mode <= slv_e'(cfg_wdata[1:0]);
                cfg.trig_ext <= cfg_wdata[2];
                cfg.ext_inv  <= cfg_wdata[3];
            end
            if (cfg_addr == A_ARR) begin
                arr <= cfg_wdata;
            end
        end
    end

    // One compare value register per channel.
    for (genvar gi = 0; gi < N_CH; gi++) begin : g_ccr
        localparam logic [ADDR_W-1:0] A_CCR = ADDR_W'(ADR_CCR0 + gi);
        // Load this channel's compare value on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ccr[gi*CNT_W +: CNT_W] <= '0;
            end else if (cfg_we && (cfg_addr == A_CCR)) begin
                ccr[gi*CNT_W +: CNT_W] <= cfg_wdata;
            end
        end
    end

endmodule

// File: rtl/tmr_count_core.sv
// Up-counter with reload, trigger polarity stage and slave handling.
// Gated mode enables the counter from the trigger registered once.
// Reset mode clears the counter on a trigger rising edge, and a delayed
// copy of that edge is kept for the master output.
module tmr_count_core
    import tmr_trig_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sw_en,
    input  slv_e             slv_mode,
    input  logic             trig_ext,
    input  logic             ext_inv,
    input  logic             ug,
    input  logic [CNT_W-1:0] arr,
    input  logic             slv_trig_in,
    input  logic             ext_trig_in,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_en,
    output logic             uev,
    output logic             rs_evt,
    output logic             rs_evt_q
);

    logic ext_act;
    logic trig;
    logic trig_q;
    logic wrap;
    logic clr;

    // Polarity stage, trigger source choice and enable / event decode.
    always_comb begin
        ext_act = ext_trig_in ^ ext_inv;
        trig    = trig_ext ? ext_act : slv_trig_in;
        rs_evt  = (slv_mode == SLV_RESET) && trig && !trig_q;
        cnt_en  = sw_en || ((slv_mode == SLV_GATE) && trig_q);
        wrap    = cnt_en && (cnt == arr);
        clr     = ug || rs_evt;
        uev     = clr || wrap;
    end

    // Trigger history for edge detection, gating and delayed reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q   <= 1'b0;
            rs_evt_q <= 1'b0;
        end else begin
            trig_q   <= trig;
            rs_evt_q <= rs_evt;
        end
    end

    // Counter: clear, wrap or step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr || wrap) begin
            cnt <= '0;
        end else if (cnt_en) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && (cnt == arr)) |=> (cnt == '0)); // R9

    AST_UG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> (cnt == '0)); // R9

    AST_GATE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        ((slv_mode == SLV_GATE) && trig) |=> ((slv_mode != SLV_GATE) || cnt_en)); // R3

endmodule

// File: rtl/tmr_cmp_bank.sv
// Compare channels: reference levels, match events, the channel-1 flag
// and the DMA request routing. A match only counts while the counter
// is enabled.
module tmr_cmp_bank #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned N_CH  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CNT_W-1:0]      cnt,
    input  logic                  cnt_en,
    input  logic [N_CH*CNT_W-1:0] ccr,
    input  logic                  uev,
    input  logic                  dma_upd,
    input  logic                  flag_clr,
    output logic [N_CH-1:0]       refs,
    output logic [N_CH-1:0]       cc_evt,
    output logic [N_CH-1:0]       dma_req,
    output logic                  cc1_flag
);

    for (genvar gi = 0; gi < N_CH; gi++) begin : g_ch
        // Level and match decode for one channel.
        always_comb begin
            refs[gi]    = cnt < ccr[gi*CNT_W +: CNT_W];
            cc_evt[gi]  = cnt_en && (cnt == ccr[gi*CNT_W +: CNT_W]);
            dma_req[gi] = dma_upd ? uev : cc_evt[gi];
        end
    end

    // Channel-1 flag; a new match wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc1_flag <= 1'b0;
        end else if (cc_evt[0]) begin
            cc1_flag <= 1'b1;
        end else if (flag_clr) begin
            cc1_flag <= 1'b0;
        end
    end

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        cc_evt[0] |=> cc1_flag); // R10

    AST_DMA_ON_UPD: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_upd && (dma_req != '0)) |-> uev); // R7

endmodule

// File: rtl/tmr_trgo_mux.sv
// Master output selector: picks one of eight sources by master mode.
// Assumes at most four reference levels are offered.
module tmr_trgo_mux
    import tmr_trig_pkg::*;
(
    input  mm_e        mode,
    input  logic       ug,
    input  logic       rs_evt_q,
    input  logic       cnt_en,
    input  logic       uev,
    input  logic       cc1_evt,
    input  logic [3:0] ref4,
    output logic       trgo
);

    // Source selection.
    always_comb begin
        unique case (mode)
            MM_UG:   trgo = ug || rs_evt_q;
            MM_EN:   trgo = cnt_en;
            MM_UPD:  trgo = uev;
            MM_CMPP: trgo = cc1_evt;
            MM_REF1: trgo = ref4[0];
            MM_REF2: trgo = ref4[1];
            MM_REF3: trgo = ref4[2];
            MM_REF4: trgo = ref4[3];
            default: trgo = 1'b0;
        endcase
    end

endmodule

// File: rtl/tmr_trig_master.sv
// Top of the master trigger timer slice: register file, counter core,
// compare bank and output selector. Assumes a single clock domain and
// trigger inputs already synchronised to it.
module tmr_trig_master
    import tmr_trig_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned N_CH   = 4,
    parameter int unsigned ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [CNT_W-1:0]  cfg_wdata,
    input  logic              slv_trig_in,
    input  logic              ext_trig_in,
    output logic              trgo,
    output logic [N_CH-1:0]   dma_req,
    output logic              cc1_flag
);

    cfg_t                  cfg;
    logic [CNT_W-1:0]      arr;
    logic [N_CH*CNT_W-1:0] ccr;
    logic                  ug;
    logic                  flag_clr;
    logic [CNT_W-1:0]      cnt;
    logic                  cnt_en;
    logic                  uev;
    logic                  rs_evt;
    logic                  rs_evt_q;
    logic [N_CH-1:0]       refs;
    logic [N_CH-1:0]       cc_evt;
    logic [3:0]            ref4;

    tmr_cfg_regs #(.CNT_W(CNT_W), .N_CH(N_CH), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg(cfg), .arr(arr), .ccr(ccr),
        .ug(ug), .flag_clr(flag_clr)
    );

    tmr_count_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .sw_en(cfg.sw_en), .slv_mode(cfg.slv_mode),
        .trig_ext(cfg.trig_ext), .ext_inv(cfg.ext_inv), .ug(ug), .arr(arr),
        .slv_trig_in(slv_trig_in), .ext_trig_in(ext_trig_in), .cnt(cnt),
        .cnt_en(cnt_en), .uev(uev), .rs_evt(rs_evt), .rs_evt_q(rs_evt_q)
    );

    tmr_cmp_bank #(.CNT_W(CNT_W), .N_CH(N_CH)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .cnt_en(cnt_en), .ccr(ccr),
        .uev(uev), .dma_upd(cfg.dma_upd), .flag_clr(flag_clr), .refs(refs),
        .cc_evt(cc_evt), .dma_req(dma_req), .cc1_flag(cc1_flag)
    );

    // Pad or trim the reference levels to the four selectable slots.
    for (genvar gk = 0; gk < 4; gk++) begin : g_ref4
        if (gk < N_CH) begin : g_have
            assign ref4[gk] = refs[gk];
        end else begin : g_none
            assign ref4[gk] = 1'b0;
        end
    end

    tmr_trgo_mux u_mux (
        .mode(cfg.mode), .ug(ug), .rs_evt_q(rs_evt_q), .cnt_en(cnt_en),
        .uev(uev), .cc1_evt(cc_evt[0]), .ref4(ref4), .trgo(trgo)
    );

    AST_RST_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.mode == MM_UG) && rs_evt) |=> ((cfg.mode != MM_UG) || trgo)); // R2

    AST_PULSE_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg.mode == MM_CMPP) && cc1_flag && cc_evt[0]) |-> trgo); // R5

    AST_TRGO_QUIET_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> (!trgo && (dma_req == '0) && !cc1_flag)); // R1

endmodule

// File: tb/tb_tmr_trig_master.sv
module tb_tmr_trig_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        slv_trig_in = 1'b0;
    logic        ext_trig_in = 1'b0;
    logic        trgo;
    logic [3:0]  dma_req;
    logic        cc1_flag;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference model state.
    logic [15:0] m_cnt, m_arr;
    logic [15:0] m_ccr [4];
    logic        m_en_sw, m_dma, m_src, m_pol, m_tq, m_rsq, m_flag;
    logic [2:0]  m_mode;
    logic [1:0]  m_slv;

    tmr_trig_master dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .slv_trig_in(slv_trig_in),
        .ext_trig_in(ext_trig_in), .trgo(trgo), .dma_req(dma_req),
        .cc1_flag(cc1_flag)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_cnt = 0; m_arr = 0; m_en_sw = 0; m_dma = 0; m_src = 0; m_pol = 0;
        m_tq = 0; m_rsq = 0; m_flag = 0; m_mode = 0; m_slv = 0;
        for (int i = 0; i < 4; i++) m_ccr[i] = 0;
    endtask

    // One clock cycle: inputs are set at the falling edge, outputs are
    // checked before the rising edge, then the model advances.
    task automatic cycle(input bit we, input logic [3:0] a, input logic [15:0] d);
        logic trig, rs, en, wrap, ug, clr, uev, e_trgo, fclr;
        logic [3:0] evt, e_dma;
        string tg;
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        #2;
        trig = m_src ? (ext_trig_in ^ m_pol) : slv_trig_in;
        rs   = (m_slv == 2'd2) && trig && !m_tq;
        en   = m_en_sw || ((m_slv == 2'd1) && m_tq);
        ug   = we && (a == 4'd3) && d[0];
        fclr = we && (a == 4'd3) && d[1];
        wrap = en && (m_cnt == m_arr);
        clr  = ug || rs;
        uev  = clr || wrap;
        for (int i = 0; i < 4; i++) begin
            evt[i]   = en && (m_cnt == m_ccr[i]);
            e_dma[i] = m_dma ? uev : evt[i];
        end
        case (m_mode)
            3'd0: begin e_trgo = ug || m_rsq; tg = "R2"; end
            3'd1: begin e_trgo = en;          tg = "R3"; end
            3'd2: begin e_trgo = uev;         tg = "R4 R9"; end
            3'd3: begin e_trgo = evt[0];      tg = "R5"; end
            default: begin
                e_trgo = m_cnt < m_ccr[m_mode - 3'd4];
                tg = "R6 R9";
            end
        endcase
        if (m_src) tg = {tg, " R8"};
        chk(trgo === e_trgo, tg, int'(trgo), int'(e_trgo));
        chk(dma_req === e_dma, "R7", int'(dma_req), int'(e_dma));
        chk(cc1_flag === m_flag, "R10", int'(cc1_flag), int'(m_flag));
        @(posedge clk);
        m_tq  = trig;
        m_rsq = rs;
        m_flag = evt[0] ? 1'b1 : (fclr ? 1'b0 : m_flag);
        if (clr || wrap) m_cnt = 0;
        else if (en) m_cnt = m_cnt + 16'd1;
        if (we) begin
            case (a)
                4'd0: m_en_sw = d[0];
                4'd1: begin m_mode = d[2:0]; m_dma = d[3]; end
                4'd2: begin m_slv = d[1:0]; m_src = d[2]; m_pol = d[3]; end
                4'd4: m_arr = d;
                4'd8, 4'd9, 4'd10, 4'd11: m_ccr[a - 4'd8] = d;
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        cycle(1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 4'd0, 16'd0);
    endtask

    task automatic run_cfg(input int mode, input bit dma);
        wr(4'd1, 16'({dma, 3'(mode)}));
        wr(4'd4, 16'd5);
        wr(4'd8, dma ? 16'd5 : 16'd2);   // match on wrap when dma=1
        wr(4'd9, 16'd3);
        wr(4'd10, 16'd0);
        wr(4'd11, 16'd6);
        wr(4'd0, 16'd1);
        idle(14);                         // repeated match with flag set
        wr(4'd3, 16'd1);                  // update strobe mid-run
        idle(3);
        wr(4'd3, 16'd2);                  // flag clear
        idle(4);
        wr(4'd0, 16'd0);
        idle(2);
        wr(4'd2, 16'd1);                  // gated by slave pin
        slv_trig_in = 1'b1; idle(5);
        slv_trig_in = 1'b0; idle(3);
        ext_trig_in = 1'b1;
        wr(4'd2, 16'hD);                  // gated by inverted external pin
        ext_trig_in = 1'b0; idle(4);
        ext_trig_in = 1'b1; idle(3);
        wr(4'd2, 16'd2);                  // reset mode from slave pin
        wr(4'd0, 16'd1);
        idle(3);
        slv_trig_in = 1'b1; idle(2);
        slv_trig_in = 1'b0; idle(3);
        slv_trig_in = 1'b1; idle(1);
        slv_trig_in = 1'b0; idle(2);
        wr(4'd0, 16'd0);
        wr(4'd2, 16'd0);
        wr(4'd3, 16'd3);
        idle(2);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: reset state at the ports
        chk(trgo === 1'b0, "R1", int'(trgo), 0);
        chk(dma_req === 4'd0, "R1", int'(dma_req), 0);
        chk(cc1_flag === 1'b0, "R1", int'(cc1_flag), 0);
        @(negedge clk);
        // R1 R2: default mode routes the update strobe
        cfg_we = 1'b1; cfg_addr = 4'd3; cfg_wdata = 16'd1;
        #2;
        chk(trgo === 1'b1, "R1 R2", int'(trgo), 1);
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
        model_reset();
        for (int m = 0; m < 8; m++) begin
            for (int dm = 0; dm < 2; dm++) begin
                run_cfg(m, dm[0]);
            end
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule